// File: doc/BRIEF.md
# Array Instruction Dispatch Queue

This block splits one in-order stream of decoded instructions between two engines: a scalar sequencing controller and a parallel processing array. Each cycle the controller may present one instruction with a tag that marks it as array-type or controller-type. Controller-type instructions are taken at once and run locally. Array-type instructions are written into a small first-in first-out queue. The array drains that queue through a valid/ready issue port whenever it is free. As a result, buffered array work runs in parallel with the controller's own instructions. The controller stalls only when it offers an array instruction and the queue has no room.

A build-time mode selects a zero-depth path instead of the queue. In that mode an array instruction goes straight to the issue port, and the controller waits until the array accepts it. Two saturating counters record stall cycles and array idle cycles, so the two modes can be compared on the same instruction stream.

Top module: `arr_dispatch_q`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, arr_valid_o is 0, in_stall_o is 0 when in_valid_i is 0, and both counters read 0.
- R2: An instruction offered with in_valid_i=1 and in_is_arr_i=0 (controller-type) never raises in_stall_o and is always consumed in that cycle.
- R3: In buffered mode, an array instruction (in_valid_i=1, in_is_arr_i=1) is accepted whenever fewer than DEPTH entries are held. in_stall_o rises only when exactly DEPTH entries are held.
- R4: Array instructions appear on arr_data_o in the exact order they were accepted, with unchanged contents. None is lost or duplicated.
- R5: An entry leaves the issue port only in a cycle where arr_valid_o and arr_ready_i are both 1. While arr_valid_o=1 and arr_ready_i=0, arr_valid_o and arr_data_o hold their values into the next cycle.
- R6: In buffered mode, arr_valid_o is 1 exactly when the queue holds at least one entry. An entry accepted at a clock edge is offered from the cycle after that edge.
- R7: In buffered mode, a full queue stalls an offered array instruction even in a cycle where the array takes the head entry. The freed slot is usable from the next cycle.
- R8: In bypass mode, arr_valid_o equals in_valid_i AND in_is_arr_i in the same cycle, and arr_data_o equals in_data_i. in_stall_o is arr_valid_o AND NOT arr_ready_i.
- R9: stall_cnt_o increments by one after each cycle with in_stall_o=1 and otherwise holds. It saturates at 2^CNT_W-1.
- R10: idle_cnt_o increments by one after each cycle with arr_ready_i=1 and arr_valid_o=0 and otherwise holds. It saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An instruction is offered this cycle |
| in_is_arr_i | input | 1 | 1: array-type instruction, 0: controller-type instruction |
| in_data_i | input | W | Decoded instruction word |
| in_stall_o | output | 1 | Offered instruction not taken; the controller must hold it |
| arr_valid_o | output | 1 | An array instruction is offered to the array |
| arr_data_o | output | W | Array instruction word |
| arr_ready_i | input | 1 | The array can take an instruction this cycle |
| stall_cnt_o | output | CNT_W | Saturating count of controller stall cycles |
| idle_cnt_o | output | CNT_W | Saturating count of cycles with the array ready and nothing offered |

## Verification
A corrupted read or write pointer shows at the issue port when the affected entry reaches the head. That is at most DEPTH pops later, as a wrong word or a repeated or skipped instruction. A wrong occupancy count shows in one of two ways: arr_valid_o is wrong in the next cycle, or in_stall_o rises too early or too late at the next array instruction offered near full. The reference model tracks occupancy and order from the ports alone, so each of these faults is flagged in the cycle it first reaches an output. The same holds for a counter that misses an increment or fails to saturate.

// File: rtl/aq_pkg.sv
`timescale 1ns/1ps
package aq_pkg;
  typedef enum logic {
    MODE_BUFFERED = 1'b0,
    MODE_BYPASS   = 1'b1
  } aq_mode_e;
endpackage

// File: rtl/aq_fifo.sv
`timescale 1ns/1ps
module aq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         empty_o,
  output logic [W-1:0] head_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;

  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/aq_sat_cnt.sv
`timescale 1ns/1ps
module aq_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (inc_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/arr_dispatch_q.sv
`timescale 1ns/1ps
module arr_dispatch_q #(
  parameter int              W     = 16,
  parameter int              DEPTH = 4,
  parameter int              CNT_W = 16,
  parameter aq_pkg::aq_mode_e MODE = aq_pkg::MODE_BUFFERED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_is_arr_i,
  input  logic [W-1:0]     in_data_i,
  output logic             in_stall_o,
  output logic             arr_valid_o,
  output logic [W-1:0]     arr_data_o,
  input  logic             arr_ready_i,
  output logic [CNT_W-1:0] stall_cnt_o,
  output logic [CNT_W-1:0] idle_cnt_o
);
  logic arr_req;
  assign arr_req = in_valid_i & in_is_arr_i;

  generate
    if (MODE == aq_pkg::MODE_BYPASS) begin : g_byp
      assign arr_valid_o = arr_req;
      assign arr_data_o  = in_data_i;
      assign in_stall_o  = arr_req & ~arr_ready_i;
    end else begin : g_buf
      logic full, empty, push, pop;
      logic [W-1:0] head;
      // full stalls even if a pop happens this cycle: keeps stall off the ready path
      assign push        = arr_req & ~full;
      assign pop         = ~empty & arr_ready_i;
      assign in_stall_o  = arr_req & full;
      assign arr_valid_o = ~empty;
      assign arr_data_o  = head;

      aq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (push),
        .data_i (in_data_i),
        .pop_i  (pop),
        .full_o (full),
        .empty_o(empty),
        .head_o (head)
      );
    end
  endgenerate

  aq_sat_cnt #(.W(CNT_W)) u_stall_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (in_stall_o),
    .cnt_o (stall_cnt_o)
  );

  aq_sat_cnt #(.W(CNT_W)) u_idle_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (arr_ready_i & ~arr_valid_o),
    .cnt_o (idle_cnt_o)
  );
endmodule

// File: rtl/aq_dispatch_chk.sv
`timescale 1ns/1ps
module aq_dispatch_chk #(
  parameter int              W     = 16,
  parameter int              DEPTH = 4,
  parameter int              CNT_W = 16,
  parameter aq_pkg::aq_mode_e MODE = aq_pkg::MODE_BUFFERED
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_is_arr_i,
  input logic [W-1:0]     in_data_i,
  input logic             in_stall_o,
  input logic             arr_valid_o,
  input logic [W-1:0]     arr_data_o,
  input logic             arr_ready_i,
  input logic [CNT_W-1:0] stall_cnt_o,
  input logic [CNT_W-1:0] idle_cnt_o
);
  int unsigned occ;
  logic acc, iss;
  assign acc = in_valid_i & in_is_arr_i & ~in_stall_o;
  assign iss = arr_valid_o & arr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ <= 0;
    else         occ <= occ + (acc ? 1 : 0) - (iss ? 1 : 0);
  end

  p_ctrl_no_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_is_arr_i) |-> !in_stall_o);

  p_stall_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_stall_o |-> (in_valid_i && in_is_arr_i));

  p_stall_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_stall_o && stall_cnt_o != '1) |=> stall_cnt_o == CNT_W'($past(stall_cnt_o) + 1'b1));

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_stall_o |=> $stable(stall_cnt_o));

  p_idle_cnt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_ready_i && !arr_valid_o && idle_cnt_o != '1) |=> idle_cnt_o == CNT_W'($past(idle_cnt_o) + 1'b1));

  generate
    if (MODE == aq_pkg::MODE_BYPASS) begin : g_byp
      p_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_valid_o == (in_valid_i && in_is_arr_i));
      p_pass_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_valid_o |-> arr_data_o == in_data_i);
    end else begin : g_buf
      p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        occ <= DEPTH);
      p_stall_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_stall_o |-> occ == DEPTH);
      p_full_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_is_arr_i && occ == DEPTH) |-> in_stall_o);
      p_valid_occ_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_valid_o == (occ != 0));
      p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arr_valid_o && !arr_ready_i) |=> (arr_valid_o && $stable(arr_data_o)));
    end
  endgenerate
endmodule

bind arr_dispatch_q aq_dispatch_chk #(
  .W(W), .DEPTH(DEPTH), .CNT_W(CNT_W), .MODE(MODE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_is_arr_i(in_is_arr_i),
  .in_data_i  (in_data_i),
  .in_stall_o (in_stall_o),
  .arr_valid_o(arr_valid_o),
  .arr_data_o (arr_data_o),
  .arr_ready_i(arr_ready_i),
  .stall_cnt_o(stall_cnt_o),
  .idle_cnt_o (idle_cnt_o)
);

// File: tb/tb_arr_dispatch_q.sv
`timescale 1ns/1ps
module tb_arr_dispatch_q;
  localparam int W     = 16;
  localparam int DEPTH = 4;
  localparam int CW_B  = 16;
  localparam int CW_Y  = 4;
  localparam int NCYC  = 2000;
  localparam int PH_A  = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // buffered instance
  logic b_v = 0, b_a = 0, b_rdy = 0, b_st, b_av;
  logic [W-1:0] b_d = '0, b_ad;
  logic [CW_B-1:0] b_sc, b_ic;
  // bypass instance
  logic y_v = 0, y_a = 0, y_rdy = 0, y_st, y_av;
  logic [W-1:0] y_d = '0, y_ad;
  logic [CW_Y-1:0] y_sc, y_ic;

  arr_dispatch_q #(.W(W), .DEPTH(DEPTH), .CNT_W(CW_B), .MODE(aq_pkg::MODE_BUFFERED)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(b_v), .in_is_arr_i(b_a), .in_data_i(b_d),
    .in_stall_o(b_st), .arr_valid_o(b_av), .arr_data_o(b_ad), .arr_ready_i(b_rdy),
    .stall_cnt_o(b_sc), .idle_cnt_o(b_ic));

  arr_dispatch_q #(.W(W), .DEPTH(DEPTH), .CNT_W(CW_Y), .MODE(aq_pkg::MODE_BYPASS)) dut_byp (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(y_v), .in_is_arr_i(y_a), .in_data_i(y_d),
    .in_stall_o(y_st), .arr_valid_o(y_av), .arr_data_o(y_ad), .arr_ready_i(y_rdy),
    .stall_cnt_o(y_sc), .idle_cnt_o(y_ic));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // program: first part repeats A A A C C C A..., later pseudo-random mix
  function automatic bit prog_arr(input int i);
    if (i < 140) return !((i % 7) >= 3 && (i % 7) <= 5);
    return ((i * 13 + i / 3) % 5) < 3;
  endfunction
  function automatic logic [W-1:0] prog_dat(input int i);
    return W'(i * 3 + 1);
  endfunction
  function automatic bit rdy_pat(input int c);
    if (c < PH_A) return (c % 4) != 3;
    if (c < 500)  return 1'b1;
    if (c < 650)  return 1'b0;
    if (c < 700)  return 1'b1;
    return ((c * 7 + c / 5) % 4) != 0;
  endfunction
  function automatic bit vld_pat(input int c);
    return (c % 13) != 12;
  endfunction

  int q[$];
  int b_idx = 0, y_idx = 0;
  int b_sc_m = 0, b_ic_m = 0, y_sc_m = 0, y_ic_m = 0;
  int b_raw_st = 0, y_raw_st = 0, b_raw_idle = 0, y_raw_idle = 0;
  bit prev_hold = 0;

  initial begin
    #10000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(b_av == 1'b0, "R1 buffered arr_valid in reset", b_av, 0);
    chk(b_st == 1'b0, "R1 buffered stall in reset", b_st, 0);
    chk(b_sc == '0 && b_ic == '0, "R1 buffered counters in reset", int'(b_sc) + int'(b_ic), 0);
    chk(y_av == 1'b0 && y_st == 1'b0, "R1 bypass outputs in reset", y_av, 0);
    chk(y_sc == '0 && y_ic == '0, "R1 bypass counters in reset", int'(y_sc) + int'(y_ic), 0);
    rst_n = 1'b1;

    for (int c = 0; c < NCYC; c++) begin
      bit e_av, e_st, pop, ye_av, ye_st;
      @(negedge clk);
      b_rdy = rdy_pat(c);
      y_rdy = b_rdy;
      b_v = vld_pat(c);
      y_v = b_v;
      b_a = prog_arr(b_idx);
      b_d = prog_dat(b_idx);
      y_a = prog_arr(y_idx);
      y_d = prog_dat(y_idx);
      #1;

      // ---- buffered model
      e_av = q.size() > 0;
      e_st = b_v && b_a && (q.size() == DEPTH);
      if (c == 0) chk(b_av == 1'b0 && b_sc == '0, "R1 first cycle after reset", b_av, 0);
      chk(b_av == e_av, "R6 buffered arr_valid", b_av, e_av);
      if (e_av) chk(b_ad == W'(q[0]), prev_hold ? "R5 held head word" : "R4 head order",
                    b_ad, q[0] % (1 << W));
      if (e_st && b_rdy)    chk(b_st == e_st, "R7 stall while head pops", b_st, e_st);
      else if (b_v && !b_a) chk(b_st == e_st, "R2 controller instr stall", b_st, e_st);
      else                  chk(b_st == e_st, "R3 buffered stall", b_st, e_st);
      chk(b_sc == CW_B'(b_sc_m), "R9 buffered stall_cnt", b_sc, b_sc_m);
      chk(b_ic == CW_B'(b_ic_m), "R10 buffered idle_cnt", b_ic, b_ic_m);

      pop = e_av && b_rdy;
      prev_hold = e_av && !b_rdy;
      if (pop) void'(q.pop_front());
      if (b_v && b_a && !e_st) q.push_back(int'(b_d));
      if (e_st && b_sc_m < (1 << CW_B) - 1) b_sc_m++;
      if (b_rdy && !e_av && b_ic_m < (1 << CW_B) - 1) b_ic_m++;
      if (c < PH_A) begin
        if (e_st) b_raw_st++;
        if (b_rdy && !e_av) b_raw_idle++;
      end
      if (b_v && !e_st) b_idx++;

      // ---- bypass model
      ye_av = y_v && y_a;
      ye_st = ye_av && !y_rdy;
      chk(y_av == ye_av, "R8 bypass arr_valid", y_av, ye_av);
      if (ye_av) chk(y_ad == y_d, "R8 bypass data", y_ad, y_d);
      chk(y_st == ye_st, (y_v && !y_a) ? "R2 bypass controller stall" : "R8 bypass stall", y_st, ye_st);
      chk(y_sc == CW_Y'(y_sc_m), "R9 bypass stall_cnt saturating", y_sc, y_sc_m);
      chk(y_ic == CW_Y'(y_ic_m), "R10 bypass idle_cnt saturating", y_ic, y_ic_m);
      if (ye_st && y_sc_m < (1 << CW_Y) - 1) y_sc_m++;
      if (y_rdy && !ye_av && y_ic_m < (1 << CW_Y) - 1) y_ic_m++;
      if (c < PH_A) begin
        if (ye_st) y_raw_st++;
        if (y_rdy && !ye_av) y_raw_idle++;
      end
      if (y_v && !ye_st) y_idx++;

      if (c == PH_A - 1) begin
        chk(b_raw_st == 0, "R3 buffered mode no stalls on interleaved stream", b_raw_st, 0);
        chk(y_raw_st > 0, "R8 bypass mode stalls on interleaved stream", y_raw_st, 1);
        chk(b_raw_idle < y_raw_idle, "R10 buffered idles less than bypass", b_raw_idle, y_raw_idle);
      end
    end

    @(negedge clk);
    chk(y_sc == '1, "R9 bypass stall_cnt saturated", y_sc, (1 << CW_Y) - 1);
    chk(y_ic == '1, "R10 bypass idle_cnt saturated", y_ic, (1 << CW_Y) - 1);
    chk(b_idx > 1000, "R4 buffered stream progress", b_idx, 1000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule